// File: doc/BRIEF.md
# Station lane-to-port configuration decoder

This block turns a 5-bit layout code for one 16-lane station into a registered description of up to four ports: for each port, whether it exists, how wide it is, and the absolute number of its first physical lane. The supported layouts mix x16, x8, x4 and x2 ports. Lanes are handed out in port order with no gaps, so each port begins on the lane just after the end of the port before it. A port that a layout does not use reports as absent, so configuration software never sees it.

The layout comes from static strap pins while reset is held. The last strap value seen before reset is released sets the starting layout. Later, a one-cycle override pulse can load a new code, for example a code fetched from a serial configuration memory after a fundamental reset. That code then takes the place of the strap layout. Codes with no defined layout raise an error flag. A second instance, built with a lane offset of 16, serves the other station.

Top module: `lane_cfg_decoder`

## Requirements
- R1: Width codes are 0=x1, 1=x2, 2=x4, 3=x8, 4=x16, and `port_en` bit i belongs to port i. Code 0 gives four ports of width code 2, code 1 gives one port of width code 4, and code 2 gives two ports of width code 3.
- R2: Code 3 gives port widths x8, x4, x4. Code 4 gives x8, x4, x2, x2. Code 5 gives x8, x2, x2, x4. Code 6 gives x8, x2, x4, x2, listed from port 0 upward. In every valid layout the lane counts of the enabled ports add up to 16.
- R3: Port 0 starts at the station lane offset. Each later enabled port starts at the start of the previous port plus that port's lane count. For example, code 5 at offset 0 gives starts 0, 8, 10 and 12.
- R4: A port that the layout does not use has enable 0, width code 0 and start 0. Enabled ports are always a contiguous group beginning at port 0.
- R5: While `rst` is high, the outputs follow `strap_code` from one clock to the next. After `rst` falls, changes on `strap_code` have no effect.
- R6: When `override_valid` is high at a clock edge, the outputs show the layout of `override_code` right after that edge. When `override_valid` is low, the outputs do not change, whatever `override_code` does.
- R7: A strap code above 6 (reserved) disables all four ports and sets `config_error` to 1.
- R8: A reserved override code sets `config_error` to 1 and leaves the existing port layout unchanged. A later valid override clears `config_error` and applies the new layout.
- R9: Every start lane reported by an enabled port includes the `LANE_OFFSET` parameter. With offset 16 and code 4, the starts are 16, 24, 28 and 30.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; strap code is sampled while high |
| strap_code | input | 5 | Static layout code from strap pins |
| override_valid | input | 1 | One-cycle pulse that loads `override_code` |
| override_code | input | 5 | Layout code that replaces the strap value |
| port_en | output | 4 | Per-port present flag, bit i for port i |
| port_width | output | 12 | Per-port width code, port i at bits [3i+2:3i] |
| port_start | output | 20 | Per-port absolute start lane, port i at bits [5i+4:5i] |
| config_error | output | 1 | Last code applied was reserved |

## Verification
The hardest state to reach is a reserved override that arrives after a valid layout is already in place. A correct block must then raise the error flag and still keep every field of the earlier layout. Anything else loses information. The stimulus first walks the valid codes through override pulses. It then sends reserved codes, so that the layout to be kept is a known mixed-width one. Finally, it resets with a reserved strap code, which leaves every port absent, and recovers from that state with a valid override.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

  localparam int WCODE_W = 3;
  localparam int MAX_VALID_CODE = 6;

  localparam logic [WCODE_W-1:0] WC_X1  = 3'd0;
  localparam logic [WCODE_W-1:0] WC_X2  = 3'd1;
  localparam logic [WCODE_W-1:0] WC_X4  = 3'd2;
  localparam logic [WCODE_W-1:0] WC_X8  = 3'd3;
  localparam logic [WCODE_W-1:0] WC_X16 = 3'd4;

  typedef struct packed {
    logic               en;
    logic [WCODE_W-1:0] wcode;
  } port_cfg_t;

  function automatic port_cfg_t make_port(input logic [WCODE_W-1:0] w);
    port_cfg_t p;
    p.en    = 1'b1;
    p.wcode = w;
    return p;
  endfunction

  function automatic logic code_reserved(input logic [7:0] code);
    return code > 8'(MAX_VALID_CODE);
  endfunction

endpackage

// File: rtl/lcd_layout_table.sv
module lcd_layout_table
  import lcd_pkg::*;
#(
  parameter int CODE_W    = 5,
  parameter int NUM_PORTS = 4
) (
  input  logic [CODE_W-1:0]               code,
  output logic                            valid,
  output port_cfg_t [NUM_PORTS-1:0]       cfg
);

  localparam int TABLE_PORTS = 4;

  port_cfg_t row [TABLE_PORTS];

  always_comb begin
    valid = 1'b1;
    for (int i = 0; i < TABLE_PORTS; i++) row[i] = '0;
    case (code)
      CODE_W'(0): begin
        row[0] = make_port(WC_X4);
        row[1] = make_port(WC_X4);
        row[2] = make_port(WC_X4);
        row[3] = make_port(WC_X4);
      end
      CODE_W'(1): begin
        row[0] = make_port(WC_X16);
      end
      CODE_W'(2): begin
        row[0] = make_port(WC_X8);
        row[1] = make_port(WC_X8);
      end
      CODE_W'(3): begin
        row[0] = make_port(WC_X8);
        row[1] = make_port(WC_X4);
        row[2] = make_port(WC_X4);
      end
      CODE_W'(4): begin
        row[0] = make_port(WC_X8);
        row[1] = make_port(WC_X4);
        row[2] = make_port(WC_X2);
        row[3] = make_port(WC_X2);
      end
      CODE_W'(5): begin
        row[0] = make_port(WC_X8);
        row[1] = make_port(WC_X2);
        row[2] = make_port(WC_X2);
        row[3] = make_port(WC_X4);
      end
      CODE_W'(6): begin
        row[0] = make_port(WC_X8);
        row[1] = make_port(WC_X2);
        row[2] = make_port(WC_X4);
        row[3] = make_port(WC_X2);
      end
      default: valid = 1'b0;
    endcase
  end

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_map
    if (i < TABLE_PORTS) begin : g_used
      assign cfg[i] = row[i];
    end else begin : g_spare
      assign cfg[i] = '0;
    end
  end

endmodule

// File: rtl/lcd_lane_packer.sv
module lcd_lane_packer
  import lcd_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int LANE_W      = 5,
  parameter int LANE_OFFSET = 0
) (
  input  port_cfg_t [NUM_PORTS-1:0]      cfg,
  output logic [NUM_PORTS*LANE_W-1:0]    start
);

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    logic [LANE_W-1:0] base;
    logic [LANE_W-1:0] lanes;

    assign lanes = cfg[i].en ? (LANE_W'(1) << cfg[i].wcode) : '0;

    if (i == 0) begin : g_first
      assign base = LANE_W'(LANE_OFFSET);
    end else begin : g_next
      assign base = g_port[i-1].base + g_port[i-1].lanes;
    end

    assign start[i*LANE_W +: LANE_W] = cfg[i].en ? base : '0;
  end

endmodule

// File: rtl/lcd_code_select.sv
module lcd_code_select #(
  parameter int CODE_W = 5
) (
  input  logic              rst,
  input  logic [CODE_W-1:0] strap_code,
  input  logic              override_valid,
  input  logic [CODE_W-1:0] override_code,
  output logic              load,
  output logic              from_strap,
  output logic [CODE_W-1:0] code
);

  // Reset has priority: strap pins are followed as long as reset is held.
  always_comb begin
    from_strap = rst;
    load       = rst | override_valid;
    code       = rst ? strap_code : override_code;
  end

endmodule

// File: rtl/lane_cfg_decoder.sv
module lane_cfg_decoder
  import lcd_pkg::*;
#(
  parameter int CODE_W      = 5,
  parameter int NUM_PORTS   = 4,
  parameter int LANE_W      = 5,
  parameter int LANE_OFFSET = 0
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [CODE_W-1:0]              strap_code,
  input  logic                           override_valid,
  input  logic [CODE_W-1:0]              override_code,
  output logic [NUM_PORTS-1:0]           port_en,
  output logic [NUM_PORTS*WCODE_W-1:0]   port_width,
  output logic [NUM_PORTS*LANE_W-1:0]    port_start,
  output logic                           config_error
);

  logic                        load;
  logic                        from_strap;
  logic [CODE_W-1:0]           sel_code;
  logic                        code_valid;
  port_cfg_t [NUM_PORTS-1:0]   dec_cfg;
  logic [NUM_PORTS*LANE_W-1:0] dec_start;
  logic [NUM_PORTS-1:0]        dec_en;
  logic [NUM_PORTS*WCODE_W-1:0] dec_width;

  lcd_code_select #(.CODE_W(CODE_W)) u_select (
    .rst            (rst),
    .strap_code     (strap_code),
    .override_valid (override_valid),
    .override_code  (override_code),
    .load           (load),
    .from_strap     (from_strap),
    .code           (sel_code)
  );

  lcd_layout_table #(.CODE_W(CODE_W), .NUM_PORTS(NUM_PORTS)) u_table (
    .code  (sel_code),
    .valid (code_valid),
    .cfg   (dec_cfg)
  );

  lcd_lane_packer #(
    .NUM_PORTS   (NUM_PORTS),
    .LANE_W      (LANE_W),
    .LANE_OFFSET (LANE_OFFSET)
  ) u_packer (
    .cfg   (dec_cfg),
    .start (dec_start)
  );

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_flat
    assign dec_en[i]                         = dec_cfg[i].en;
    assign dec_width[i*WCODE_W +: WCODE_W]   = dec_cfg[i].wcode;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      if (code_valid) begin
        port_en      <= dec_en;
        port_width   <= dec_width;
        port_start   <= dec_start;
        config_error <= 1'b0;
      end else begin
        config_error <= 1'b1;
        if (from_strap) begin
          port_en    <= '0;
          port_width <= '0;
          port_start <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/lane_cfg_decoder_chk.sv
module lane_cfg_decoder_chk
  import lcd_pkg::*;
#(
  parameter int CODE_W      = 5,
  parameter int NUM_PORTS   = 4,
  parameter int LANE_W      = 5,
  parameter int LANE_OFFSET = 0
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           override_valid,
  input logic [CODE_W-1:0]              override_code,
  input logic [NUM_PORTS-1:0]           port_en,
  input logic [NUM_PORTS*WCODE_W-1:0]   port_width,
  input logic [NUM_PORTS*LANE_W-1:0]    port_start,
  input logic                           config_error
);

  logic [LANE_W:0] lane_sum;

  always_comb begin
    lane_sum = '0;
    for (int i = 0; i < NUM_PORTS; i++)
      if (port_en[i])
        lane_sum = lane_sum + ((LANE_W+1)'(1) << port_width[i*WCODE_W +: WCODE_W]);
  end

  // R2
  lane_total_chk: assert property (@(posedge clk) disable iff (rst)
    (port_en != '0) |-> (lane_sum == (LANE_W+1)'(16)));

  // R9
  first_start_chk: assert property (@(posedge clk) disable iff (rst)
    port_en[0] |-> (port_start[LANE_W-1:0] == LANE_W'(LANE_OFFSET)));

  // R6
  hold_layout_chk: assert property (@(posedge clk) disable iff (rst)
    !override_valid |=> ($stable(port_en) && $stable(port_width) &&
                         $stable(port_start) && $stable(config_error)));

  // R8
  reserved_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (override_valid && code_reserved(8'(override_code))) |=>
      (config_error && $stable(port_en) && $stable(port_width) && $stable(port_start)));

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    // R4
    absent_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !port_en[i] |-> (port_width[i*WCODE_W +: WCODE_W] == '0 &&
                       port_start[i*LANE_W +: LANE_W] == '0));
    if (i > 0) begin : g_chain
      // R4
      contiguous_chk: assert property (@(posedge clk) disable iff (rst)
        port_en[i] |-> port_en[i-1]);
      // R3
      start_chain_chk: assert property (@(posedge clk) disable iff (rst)
        port_en[i] |-> (port_start[i*LANE_W +: LANE_W] ==
          port_start[(i-1)*LANE_W +: LANE_W] +
          (LANE_W'(1) << port_width[(i-1)*WCODE_W +: WCODE_W])));
    end
  end

endmodule

bind lane_cfg_decoder lane_cfg_decoder_chk #(
  .CODE_W      (CODE_W),
  .NUM_PORTS   (NUM_PORTS),
  .LANE_W      (LANE_W),
  .LANE_OFFSET (LANE_OFFSET)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .override_valid (override_valid),
  .override_code  (override_code),
  .port_en        (port_en),
  .port_width     (port_width),
  .port_start     (port_start),
  .config_error   (config_error)
);

// File: tb/lane_cfg_decoder_bench.sv
`timescale 1ns/1ps
module lane_cfg_decoder_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  strap_code = 5'd5;
  logic        override_valid = 1'b0;
  logic [4:0]  override_code = 5'd0;
  logic [3:0]  port_en;
  logic [11:0] port_width;
  logic [19:0] port_start;
  logic        config_error;

  logic [4:0]  strap1 = 5'd4;
  logic        ov1 = 1'b0;
  logic [4:0]  oc1 = 5'd0;
  logic [3:0]  en1;
  logic [11:0] w1;
  logic [19:0] s1;
  logic        err1;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lane_cfg_decoder u_lane_cfg_decoder (
    .clk(clk), .rst(rst), .strap_code(strap_code),
    .override_valid(override_valid), .override_code(override_code),
    .port_en(port_en), .port_width(port_width), .port_start(port_start),
    .config_error(config_error)
  );

  lane_cfg_decoder #(.LANE_OFFSET(16)) u_lane_cfg_decoder_stn1 (
    .clk(clk), .rst(rst), .strap_code(strap1),
    .override_valid(ov1), .override_code(oc1),
    .port_en(en1), .port_width(w1), .port_start(s1), .config_error(err1)
  );

  // Vectors: code, expected enable, widths {p3,p2,p1,p0}, starts {p3,p2,p1,p0}, error
  localparam int NV = 9;
  localparam logic [4:0]  V_CODE [NV] = '{5'd3, 5'd0, 5'd1, 5'd6, 5'd2, 5'd5, 5'd4, 5'd7, 5'd31};
  localparam logic [3:0]  V_EN   [NV] = '{4'h7, 4'hF, 4'h1, 4'hF, 4'h3, 4'hF, 4'hF, 4'hF, 4'hF};
  localparam logic [11:0] V_W    [NV] = '{
    {3'd0,3'd2,3'd2,3'd3}, {3'd2,3'd2,3'd2,3'd2}, {3'd0,3'd0,3'd0,3'd4},
    {3'd1,3'd2,3'd1,3'd3}, {3'd0,3'd0,3'd3,3'd3}, {3'd2,3'd1,3'd1,3'd3},
    {3'd1,3'd1,3'd2,3'd3}, {3'd1,3'd1,3'd2,3'd3}, {3'd1,3'd1,3'd2,3'd3}};
  localparam logic [19:0] V_S    [NV] = '{
    {5'd0,5'd12,5'd8,5'd0}, {5'd12,5'd8,5'd4,5'd0}, {5'd0,5'd0,5'd0,5'd0},
    {5'd14,5'd10,5'd8,5'd0}, {5'd0,5'd0,5'd8,5'd0}, {5'd12,5'd10,5'd8,5'd0},
    {5'd14,5'd12,5'd8,5'd0}, {5'd14,5'd12,5'd8,5'd0}, {5'd14,5'd12,5'd8,5'd0}};
  localparam logic        V_ERR  [NV] = '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1};
  localparam string       V_REQ  [NV] = '{"R2","R1","R1","R2","R1","R3","R2","R8","R8"};

  task automatic check(input string req, input logic [3:0] ae, input logic [11:0] aw,
                       input logic [19:0] as, input logic aerr, input logic [3:0] ee,
                       input logic [11:0] ew, input logic [19:0] es, input logic eerr);
    checks++;
    if (ae !== ee || aw !== ew || as !== es || aerr !== eerr) begin
      errors++;
      $display("FAIL %s: actual en=%h w=%h s=%h err=%b expected en=%h w=%h s=%h err=%b",
               req, ae, aw, as, aerr, ee, ew, es, eerr);
    end
  endtask

  task automatic pulse(input logic [4:0] c);
    @(negedge clk);
    override_code  = c;
    override_valid = 1'b1;
    @(negedge clk);
    override_valid = 1'b0;
  endtask

  task automatic do_reset(input logic [4:0] s);
    @(negedge clk);
    rst = 1'b1;
    strap_code = s;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R5: layout from strap code 5 after reset
    do_reset(5'd5);
    check("R5", port_en, port_width, port_start, config_error,
          4'hF, {3'd2,3'd1,3'd1,3'd3}, {5'd12,5'd10,5'd8,5'd0}, 1'b0);
    // R9: station with offset 16, strap code 4
    check("R9", en1, w1, s1, err1,
          4'hF, {3'd1,3'd1,3'd2,3'd3}, {5'd30,5'd28,5'd24,5'd16}, 1'b0);

    // R5: strap changes after reset are ignored
    strap_code = 5'd1;
    repeat (3) @(negedge clk);
    check("R5", port_en, port_width, port_start, config_error,
          4'hF, {3'd2,3'd1,3'd1,3'd3}, {5'd12,5'd10,5'd8,5'd0}, 1'b0);

    // R6: override code without a valid pulse has no effect
    override_code = 5'd2;
    repeat (3) @(negedge clk);
    check("R6", port_en, port_width, port_start, config_error,
          4'hF, {3'd2,3'd1,3'd1,3'd3}, {5'd12,5'd10,5'd8,5'd0}, 1'b0);

    // R1 R2 R3 R6 R8: vector walk through override pulses
    for (int k = 0; k < NV; k++) begin
      pulse(V_CODE[k]);
      check(V_REQ[k], port_en, port_width, port_start, config_error,
            V_EN[k], V_W[k], V_S[k], V_ERR[k]);
    end

    // R7: reserved strap disables all ports
    do_reset(5'd9);
    check("R7", port_en, port_width, port_start, config_error,
          4'h0, 12'h000, 20'h00000, 1'b1);

    // R8: valid override clears the error
    pulse(5'd2);
    check("R8", port_en, port_width, port_start, config_error,
          4'h3, {3'd0,3'd0,3'd3,3'd3}, {5'd0,5'd0,5'd8,5'd0}, 1'b0);

    // R8: reserved override keeps the two-port layout
    pulse(5'd15);
    check("R8", port_en, port_width, port_start, config_error,
          4'h3, {3'd0,3'd0,3'd3,3'd3}, {5'd0,5'd0,5'd8,5'd0}, 1'b1);

    // R4: single-port layout leaves ports 1..3 absent
    pulse(5'd1);
    check("R4", port_en, port_width, port_start, config_error,
          4'h1, {3'd0,3'd0,3'd0,3'd4}, 20'h00000, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule